// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block sits in the read data path of a flash memory and shapes what a host sees while the array is busy with an internal program or erase. The host polls by reading, and two status indicators are substituted into the returned byte. The top data bit carries a completion flag: during a program it is the inverse of the top bit of the byte being written, and during an erase it reads low. The bit below it flips on every status read for as long as the array is busy, and it starts low on the first read of each new operation. The remaining bits pass the current array contents through.

When the operation finishes, reads return the true array contents again. The lower bits of the array output may not have settled yet, so for a configurable number of clocks after busy falls only the top bit is true and the lower bits read as zero. A read whose address is outside the decoded range gets no status substitution and does not advance the flip bit. The command sequencer that raises busy, and the array itself, are outside this block. The sequencer raises busy from the write strobe that completes the command: the fourth for a program, the sixth for an erase.

Top module: `flash_poll_resp`

## Requirements
- R1: After reset, `rdData` is all zeros.
- R2: `rdData` is registered. It is updated at the rising edge where `rdStrobe` is high and holds its value at every other edge, whatever the other inputs do.
- R3: A read with `busy`=1, `addrInRange`=1 and `opErase`=0 returns bit DW-1 equal to the inverse of `progByte[DW-1]`.
- R4: A read with `busy`=1, `addrInRange`=1 and `opErase`=1 returns bit DW-1 equal to 0.
- R5: During one busy period, in-range reads return bit DW-2 as 0, 1, 0, 1, and so on, in read order, starting with 0 on the first such read.
- R6: During an in-range busy read, bits DW-3..0 equal `arrData[DW-3:0]`.
- R7: When `busy` is low and no settle window is open, a read returns `arrData` unchanged. This covers an erased location reading its top bit as 1, and bit DW-2 no longer flipping.
- R8: A read with `busy`=1 and `addrInRange`=0 returns `arrData` unchanged and does not advance the R5 sequence.
- R9: The settle window is the SETTLE_CLKS clock cycles that start with the first cycle in which `busy` is low after being high. A read in this window returns `arrData[DW-1]` in bit DW-1 and zeros in all lower bits.
- R10: A new operation, meaning a rising edge of `busy`, restarts the R5 sequence at 0. This holds when the previous operation left the flip bit at 1, and when a read falls in the same cycle that `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Read request, one per high cycle |
| addrInRange | input | 1 | Read address lies in the decoded range |
| busy | input | 1 | Internal program or erase in progress |
| opErase | input | 1 | 1 = erase, 0 = program |
| progByte | input | DW | Byte being programmed |
| arrData | input | DW | Current array read data |
| rdData | output | DW | Returned read data |

## Verification
Two events can land on the same clock edge: the start of a new operation, which clears the flip bit, and a status read, which advances it. The bench raises `busy` and `rdStrobe` in the same cycle, straight after an operation that left the flip bit at 1, and requires bit 6 of that read to be 0 and bit 6 of the next read to be 1. The second coincidence is the end of an operation landing on a read. Here the bench keeps reading from the first cycle in which `busy` is low, and judges each read against the position of that cycle relative to the settle window.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [1:0] {
    MUX_PASS   = 2'd0,
    MUX_STATUS = 2'd1,
    MUX_SETTLE = 2'd2
  } muxSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    muxSelE sel;
    logic   togBit;
    logic   eraseOp;
  } ctrlStrobeT;

endpackage

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int SETTLE_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStrobe,
  input  logic       addrInRange,
  input  logic       busy,
  input  logic       opErase,
  output ctrlStrobeT strobe
);

  localparam int CW = (SETTLE_CLKS > 0) ? $clog2(SETTLE_CLKS + 1) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'((SETTLE_CLKS > 0) ? SETTLE_CLKS - 1 : 0);
  localparam bit HAS_SETTLE = (SETTLE_CLKS > 0);

  logic          busyQ;
  logic          togQ;
  logic [CW-1:0] settleCnt;

  logic startOp, endOp, statusRead, togNow, settleAct;

  assign startOp    = busy & ~busyQ;
  assign endOp      = ~busy & busyQ;
  assign statusRead = rdStrobe & busy & addrInRange;
  assign togNow     = startOp ? 1'b0 : togQ;
  assign settleAct  = ~busy & (endOp ? HAS_SETTLE : (settleCnt != '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      togQ      <= 1'b0;
      settleCnt <= '0;
    end else begin
      busyQ <= busy;
      togQ  <= statusRead ? ~togNow : togNow;
      if (busy)
        settleCnt <= '0;
      else if (endOp)
        settleCnt <= LOAD_VAL;
      else if (settleCnt != '0)
        settleCnt <= settleCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.load    = rdStrobe;
    strobe.togBit  = togNow;
    strobe.eraseOp = opErase;
    if (settleAct)
      strobe.sel = MUX_SETTLE;
    else if (statusRead)
      strobe.sel = MUX_STATUS;
    else
      strobe.sel = MUX_PASS;
  end

  // R5: each status read outside an operation start flips the toggle state
  assert_tog_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !startOp) |=> (togQ != $past(togQ)));

  // R8: out-of-range busy read leaves the toggle state untouched
  assert_oor_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyQ && rdStrobe && !addrInRange) |=> $stable(togQ));

  // R9: no settle count survives a busy cycle
  assert_settle_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (settleCnt == '0));

endmodule

// File: rtl/flash_poll_dp.sv
module flash_poll_dp
  import flash_poll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeT    strobe,
  input  logic [DW-1:0] progByte,
  input  logic [DW-1:0] arrData,
  output logic [DW-1:0] rdData
);

  localparam int FLAG_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic [DW-1:0] nextData;

  always_comb begin
    nextData = arrData;
    unique case (strobe.sel)
      MUX_STATUS: begin
        nextData[FLAG_BIT] = strobe.eraseOp ? 1'b0 : ~progByte[FLAG_BIT];
        nextData[TOG_BIT]  = strobe.togBit;
      end
      MUX_SETTLE: begin
        nextData           = '0;
        nextData[FLAG_BIT] = arrData[FLAG_BIT];
      end
      default: nextData = arrData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strobe.load)
      rdData <= nextData;
  end

  // R2: output holds without a read
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(rdData));

  // R3: program polling inverts the top bit of the written byte
  assert_prog_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.sel == MUX_STATUS && !strobe.eraseOp)
      |=> (rdData[FLAG_BIT] != $past(progByte[FLAG_BIT])));

  // R4: erase polling reads the top bit low
  assert_erase_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.sel == MUX_STATUS && strobe.eraseOp)
      |=> (rdData[FLAG_BIT] == 1'b0));

  // R7: plain reads return the array byte
  assert_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.sel == MUX_PASS) |=> (rdData == $past(arrData)));

endmodule

// File: rtl/flash_poll_resp.sv
module flash_poll_resp
  import flash_poll_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETTLE_CLKS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdStrobe,
  input  logic          addrInRange,
  input  logic          busy,
  input  logic          opErase,
  input  logic [DW-1:0] progByte,
  input  logic [DW-1:0] arrData,
  output logic [DW-1:0] rdData
);

  ctrlStrobeT strobe;

  flash_poll_ctrl #(.SETTLE_CLKS(SETTLE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .addrInRange(addrInRange),
    .busy(busy), .opErase(opErase), .strobe(strobe)
  );

  flash_poll_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .progByte(progByte),
    .arrData(arrData), .rdData(rdData)
  );

  // R1: output is zero right after reset
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (rdData == '0));

endmodule

// File: tb/sim_flash_poll_resp.sv
module sim_flash_poll_resp;

  localparam int DW     = 8;
  localparam int SETTLE = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdStrobe = 1'b0;
  logic          addrInRange = 1'b1;
  logic          busy = 1'b0;
  logic          opErase = 1'b0;
  logic [DW-1:0] progByte = '0;
  logic [DW-1:0] arrData = '0;
  logic [DW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_poll_resp #(.DW(DW), .SETTLE_CLKS(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .addrInRange(addrInRange),
    .busy(busy), .opErase(opErase), .progByte(progByte), .arrData(arrData),
    .rdData(rdData)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one read cycle: returns data registered at the edge of that cycle
  task automatic doRead(input logic inRange, output logic [DW-1:0] got);
    @(negedge clk);
    rdStrobe = 1'b1;
    addrInRange = inRange;
    @(negedge clk);
    rdStrobe = 1'b0;
    addrInRange = 1'b1;
    got = rdData;
  endtask

  task automatic startOp(input logic erase, input logic [DW-1:0] pb);
    @(negedge clk);
    opErase = erase;
    progByte = pb;
    busy = 1'b1;
  endtask

  task automatic endOpQuiet();
    @(negedge clk);
    busy = 1'b0;
    repeat (SETTLE + 2) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1", rdData, '0);
  endtask

  task automatic testProgram();
    logic [DW-1:0] g;
    arrData = 8'h15;
    startOp(1'b0, 8'h3C);
    doRead(1'b1, g);
    check("R3/R5/R6 first program read", g, {1'b1, 1'b0, 6'h15});
    arrData = 8'h2A;
    doRead(1'b1, g);
    check("R5/R6 second program read", g, {1'b1, 1'b1, 6'h2A});
    progByte = 8'hC3;
    doRead(1'b1, g);
    check("R3/R5 third program read", g, {1'b0, 1'b0, 6'h2A});
    endOpQuiet();
  endtask

  task automatic testHold();
    logic [DW-1:0] g;
    arrData = 8'h5A;
    doRead(1'b1, g);
    check("R7 idle read", g, 8'h5A);
    arrData = 8'hC3;
    repeat (3) @(negedge clk);
    check("R2 hold without read", rdData, 8'h5A);
  endtask

  task automatic testEraseAndRange();
    logic [DW-1:0] g;
    arrData = 8'hFF;
    startOp(1'b1, 8'h00);
    doRead(1'b1, g);
    check("R4/R5 erase read 1", g, 8'h3F);
    doRead(1'b0, g);
    check("R8 out of range read", g, 8'hFF);
    doRead(1'b1, g);
    check("R8/R5 toggle not advanced", g, 8'h7F);
    doRead(1'b1, g);
    check("R4/R5 erase read 3", g, 8'h3F);
    doRead(1'b1, g);
    check("R5 erase read 4 leaves toggle 1", g, 8'h7F);
  endtask

  task automatic testSettle();
    logic [DW-1:0] g;
    arrData = 8'hA5;
    @(negedge clk);
    busy = 1'b0;
    rdStrobe = 1'b1;
    for (int i = 0; i <= SETTLE; i++) begin
      @(negedge clk);
      g = rdData;
      if (i < SETTLE) check("R9 settle window read", g, 8'h80);
      else            check("R7 read after settle", g, 8'hA5);
    end
    rdStrobe = 1'b0;
    arrData = 8'hFF;
    doRead(1'b1, g);
    check("R7 erased byte, toggle stopped", g, 8'hFF);
    doRead(1'b1, g);
    check("R7 erased byte again", g, 8'hFF);
  endtask

  task automatic testRestartCollision();
    logic [DW-1:0] g;
    // previous op ended with toggle at 1; start and read in same cycle
    arrData = 8'h01;
    @(negedge clk);
    opErase = 1'b0;
    progByte = 8'h80;
    busy = 1'b1;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    g = rdData;
    check("R10 read on start cycle", g, 8'h01);
    doRead(1'b1, g);
    check("R10 next read toggles", g, 8'h41);
    endOpQuiet();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testProgram();
    testHold();
    testEraseAndRange();
    testSettle();
    // leave toggle at 1 before restart
    startOp(1'b0, 8'h00);
    begin
      logic [DW-1:0] g;
      arrData = 8'h00;
      doRead(1'b1, g);
      check("R3/R5 single read before restart", g, 8'h80);
    end
    endOpQuiet();
    testRestartCollision();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule